// File: doc/BRIEF.md
# Saturating 16-bit DSP ALU with Shadow Register Bank

This block is the integer arithmetic/logic stage of a fixed-point signal-processing datapath. It holds six 16-bit working registers in a register file:

- two X operand registers;
- two Y operand registers;
- a feedback register;
- a result register.

An X operand is taken from one of the X registers or from an external result-bus input. A Y operand is taken from one of the Y registers or from the feedback register. A 4-bit opcode selects the operation, and the outcome is written back to either the result register or the feedback register.

Every operation latches a status word. The carry bit of that status word feeds the carry-in of the with-carry add and subtract operations, so that multiword sums can be chained across cycles. A saturation enable clamps an overflowing result to the extreme representable value before it lands in the result register.

The whole register file exists twice. A bank select input chooses which copy is active, so an interrupt handler can switch context in one cycle without saving anything. A simple write port loads any register of the active bank. A read port returns any register of the active bank.

Top module: `dsp_alu16`

## Requirements
- R1: After reset, every register of both banks reads 0 and the status word is 0.
- R2: When `wr_en` is high, `wr_data` is loaded at the next clock edge into the active-bank register picked by `wr_sel`. The `wr_sel` and `rd_sel` codes are: 0 = X0, 1 = X1, 2 = Y0, 3 = Y1, 4 = feedback, 5 = result. Codes 6 and 7 write nothing, and reading them returns 0.
- R3: The `x_src` input selects the X operand: 0 = X0, 1 = X1, 2 or 3 = `rbus`. The `y_src` input selects the Y operand: 0 = Y0, 1 = Y1, 2 or 3 = the feedback register.
- R4: The arithmetic opcodes are:
  - 0 = x+y;
  - 1 = x+y+C;
  - 2 = x-y;
  - 3 = x-y-1+C;
  - 4 = -x;
  - 5 = x+1;
  - 6 = x-1;
  - 7 = |x|.

  C is the stored carry flag. All results are taken modulo 2^16.
- R5: The logic opcodes are 8 = x AND y, 9 = x OR y, 10 = x XOR y and 11 = NOT x. They clear both the carry flag and the overflow flag.
- R6: Each valid operation latches the status word. Bit 0 is zero, set when the unsaturated result is 0. Bit 1 is negative, equal to the result's bit 15. Bit 2 is overflow, set on a two's-complement overflow. Bit 3 is carry, the 17th bit of the internal adder: for the subtract opcodes this is 1 when no borrow occurs, and for -x it is 1 only when x is 0.
- R7: Status bit 4 (sign) is set to bit 15 of x by opcode 7 and is cleared by every other valid opcode. Status bit 5 (quotient) is never changed by the ALU and stays 0.
- R8: `dest` = 0 writes the result register and `dest` = 1 writes the feedback register.
- R9: When `sat_en` is high, the destination is the result register and the operation overflows, the result register receives 0x7FFF for a positive overflow and 0x8000 for a negative one. The feedback register is never saturated, and nothing is saturated when `sat_en` is low.
- R10: Writes and operations touch only the bank selected by `bank_sel`, and switching banks preserves both banks' contents. The status word is shared by both banks.
- R11: Opcodes 12 to 15, and cycles with `op_valid` low, change neither the registers nor the status word. When the operation result and the write port target the same register in one cycle, the operation result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 1 | Active register bank |
| sat_en | input | 1 | Saturation enable for the result register |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 3 | Write port register code |
| wr_data | input | 16 | Write port data |
| op_valid | input | 1 | Execute the opcode this cycle |
| opcode | input | 4 | Operation code |
| x_src | input | 2 | X operand source |
| y_src | input | 2 | Y operand source |
| dest | input | 1 | 0 = result register, 1 = feedback register |
| rbus | input | 16 | External result-bus value for X |
| rd_sel | input | 3 | Read port register code |
| rd_data | output | 16 | Active-bank register picked by `rd_sel` |
| r_out | output | 16 | Active-bank result register |
| status | output | 6 | Latched status word |

## Verification
The hardest situations to reach are those where two pieces of state interact across cycles:

- a carry produced by one operation feeding a with-carry operation in the next;
- a saturating overflow landing in a bank that is later switched away from and back to.

The stimulus builds a two-word addition whose low half carries out and a two-word subtraction whose low half borrows. It forces overflow in both directions with operands such as 0x7FFF+1 and 0x8000-1, and performs -x and |x| on 0x8000. It loads different values into the two banks and switches between them around operations.

A behavioural model computes every result with signed and unsigned integers and is compared on every clock. A long stream of mixed random cycles then covers collisions between the write port and the operation result.

// File: rtl/dsp_alu16.sv
module dsp_alu16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bank_sel,
  input  logic         sat_en,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         op_valid,
  input  logic [3:0]   opcode,
  input  logic [1:0]   x_src,
  input  logic [1:0]   y_src,
  input  logic         dest,
  input  logic [W-1:0] rbus,
  input  logic [2:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] r_out,
  output logic [5:0]   status
);
  localparam int NREG = 6;
  localparam int IX0 = 0, IX1 = 1, IY0 = 2, IY1 = 3, IFB = 4, IRS = 5;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAXN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] rf [2][NREG];
  logic [W-1:0] xv, yv, a, b, res, wval;
  logic [W:0]   sum;
  logic         cin, arith, ovf, sflag, op_ok;

  assign xv = (x_src == 2'd0) ? rf[bank_sel][IX0] :
              (x_src == 2'd1) ? rf[bank_sel][IX1] : rbus;
  assign yv = (y_src == 2'd0) ? rf[bank_sel][IY0] :
              (y_src == 2'd1) ? rf[bank_sel][IY1] : rf[bank_sel][IFB];

  always_comb begin
    a = xv; b = yv; cin = 1'b0; arith = 1'b1;
    case (opcode)
      4'd1: cin = status[3];
      4'd2: begin b = ~yv; cin = 1'b1; end
      4'd3: begin b = ~yv; cin = status[3]; end
      4'd4: begin a = '0; b = ~xv; cin = 1'b1; end
      4'd5: begin b = '0; cin = 1'b1; end
      4'd6: b = '1;
      4'd7: if (xv[W-1]) begin a = '0; b = ~xv; cin = 1'b1; end
            else b = '0;
      4'd0: ;
      default: arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign ovf = arith && (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  assign sflag = (opcode == 4'd7) && xv[W-1];
  assign op_ok = op_valid && (opcode < 4'd12);

  always_comb begin
    case (opcode)
      4'd8:    res = xv & yv;
      4'd9:    res = xv | yv;
      4'd10:   res = xv ^ yv;
      4'd11:   res = ~xv;
      default: res = sum[W-1:0];
    endcase
  end

  assign wval = (sat_en && ovf && !dest) ? (a[W-1] ? MAXN : MAXP) : res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++)
        for (int i = 0; i < NREG; i++) rf[k][i] <= '0;
      status <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_en && wr_sel == i[2:0]) rf[bank_sel][i] <= wr_data;
      if (op_ok) begin
        if (dest) rf[bank_sel][IFB] <= wval;
        else      rf[bank_sel][IRS] <= wval;
        status <= {status[5], sflag, arith && sum[W], ovf, res[W-1], res == '0};
      end
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0: rd_data = rf[bank_sel][IX0];
      3'd1: rd_data = rf[bank_sel][IX1];
      3'd2: rd_data = rf[bank_sel][IY0];
      3'd3: rd_data = rf[bank_sel][IY1];
      3'd4: rd_data = rf[bank_sel][IFB];
      3'd5: rd_data = rf[bank_sel][IRS];
      default: rd_data = '0;
    endcase
  end
  assign r_out = rf[bank_sel][IRS];

  // R9
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ok && sat_en && !dest && ovf |=>
      (bank_sel != $past(bank_sel)) || r_out == MAXP || r_out == MAXN);
  // R11
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ok |=> $stable(status));
  // R7
  sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ok && opcode != 4'd7 |=> !status[4]);
  // R7
  quot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(status[5]));
  // R5
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ok && opcode >= 4'd8 |=> !status[2] && !status[3]);
  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ok |=> status[1] == $past(res[W-1]));
endmodule

// File: tb/sim_dsp_alu16.sv
module sim_dsp_alu16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_sel = 0, sat_en = 0, wr_en = 0, op_valid = 0, dest = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = 0, rbus = 0;
  logic [3:0] opcode = 0;
  logic [1:0] x_src = 0, y_src = 0;
  logic [15:0] rd_data, r_out;
  logic [5:0] status;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] m [2][6];
  logic [5:0] mst;

  always #10 clk = ~clk;

  dsp_alu16 u0 (.clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .sat_en(sat_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .op_valid(op_valid),
    .opcode(opcode), .x_src(x_src), .y_src(y_src), .dest(dest), .rbus(rbus),
    .rd_sel(rd_sel), .rd_data(rd_data), .r_out(r_out), .status(status));

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(bit bk, int rs);
    return (rs < 6) ? m[bk][rs] : 16'h0000;
  endfunction

  task automatic step(string req, bit bk, bit sat, bit we, int ws, int wd,
                      bit ov, int op, int xs, int ys, bit ds, int rb, int rs);
    int x, y, sx, sy, s, ideal, cf;
    bit c, v, sf, arith;
    logic [15:0] res, val;
    @(negedge clk);
    bank_sel = bk; sat_en = sat; wr_en = we; wr_sel = ws[2:0]; wr_data = wd[15:0];
    op_valid = ov; opcode = op[3:0]; x_src = xs[1:0]; y_src = ys[1:0]; dest = ds;
    rbus = rb[15:0]; rd_sel = rs[2:0];
    #1;
    chk(req, "rd_data", rd_data, mread(bk, rs));
    chk(req, "r_out", r_out, m[bk][5]);
    chk(req, "status", {10'd0, status}, {10'd0, mst});
    x = (xs == 0) ? m[bk][0] : (xs == 1) ? m[bk][1] : rb & 16'hFFFF;
    y = (ys == 0) ? m[bk][2] : (ys == 1) ? m[bk][3] : m[bk][4];
    sx = (x >= 32768) ? x - 65536 : x;
    sy = (y >= 32768) ? y - 65536 : y;
    cf = mst[3];
    sf = 0; arith = 1; ideal = 0; s = 0;
    case (op & 15)
      0: begin s = x + y; ideal = sx + sy; end
      1: begin s = x + y + cf; ideal = sx + sy + cf; end
      2: begin s = x - y + 65536; ideal = sx - sy; end
      3: begin s = x - y - 1 + cf + 65536; ideal = sx - sy - 1 + cf; end
      4: begin s = 65536 - x; ideal = -sx; end
      5: begin s = x + 1; ideal = sx + 1; end
      6: begin s = x + 65535; ideal = sx - 1; end
      7: begin s = (sx < 0) ? 65536 - x : x; ideal = (sx < 0) ? -sx : sx; sf = (sx < 0); end
      8: begin s = x & y; arith = 0; end
      9: begin s = x | y; arith = 0; end
      10: begin s = x ^ y; arith = 0; end
      default: begin s = 65535 - x; arith = 0; end
    endcase
    res = s[15:0];
    c = arith && (s >= 65536);
    v = arith && (ideal > 32767 || ideal < -32768);
    val = (sat && v && !ds) ? ((ideal > 0) ? 16'h7FFF : 16'h8000) : res;
    if (we && ws < 6) m[bk][ws] = wd[15:0];
    if (ov && op < 12) begin
      m[bk][ds ? 4 : 5] = val;
      mst = {mst[5], sf, c, v, res[15], res == 16'h0000};
    end
  endtask

  task automatic wr(string req, bit bk, int ws, int wd);
    step(req, bk, 0, 1, ws, wd, 0, 0, 0, 0, 0, 0, ws);
  endtask

  task automatic op1(string req, bit bk, bit sat, int op, int xs, int ys, bit ds, int rb);
    step(req, bk, sat, 0, 0, 0, 1, op, xs, ys, ds, rb, 5);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) for (int i = 0; i < 6; i++) m[k][i] = 0;
    mst = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "r_out", r_out, 16'h0);
    chk("R1", "status", {10'd0, status}, 16'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, i);
    for (int i = 0; i < 8; i++) step("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, i);
    // R2 write port, including unused codes
    wr("R2", 0, 0, 16'h1234); wr("R2", 0, 1, 16'h00F0); wr("R2", 0, 2, 16'h0011);
    wr("R2", 0, 3, 16'hFF00); wr("R2", 0, 4, 16'h0100); wr("R2", 0, 5, 16'hABCD);
    wr("R2", 0, 6, 16'hDEAD); wr("R2", 0, 7, 16'hBEEF);
    for (int i = 0; i < 8; i++) step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, i);
    // R3 operand sources
    op1("R3", 0, 0, 0, 0, 0, 0, 0); op1("R3", 0, 0, 0, 1, 1, 0, 0);
    op1("R3", 0, 0, 0, 2, 2, 0, 16'h0005); op1("R3", 0, 0, 0, 3, 3, 1, 16'h0007);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);
    // R4 multiword add: low half carries out
    wr("R4", 0, 0, 16'hFFFF); wr("R4", 0, 2, 16'h0001);
    op1("R4", 0, 0, 0, 0, 0, 0, 0);
    wr("R4", 0, 1, 16'h0010); wr("R4", 0, 3, 16'h0020);
    op1("R4", 0, 0, 1, 1, 1, 0, 0);
    // R4 multiword subtract: low half borrows
    op1("R4", 0, 0, 2, 2, 0, 0, 16'h0000);
    op1("R4", 0, 0, 3, 1, 1, 0, 0);
    op1("R4", 0, 0, 4, 2, 0, 0, 16'h0000);
    op1("R4", 0, 0, 4, 2, 0, 0, 16'h0003);
    op1("R4", 0, 0, 5, 2, 0, 0, 16'hFFFF);
    op1("R4", 0, 0, 6, 2, 0, 0, 16'h0000);
    // R7 sign flag on absolute value
    op1("R7", 0, 0, 7, 2, 0, 0, 16'hFFF6);
    op1("R7", 0, 0, 7, 2, 0, 0, 16'h0009);
    op1("R7", 0, 0, 7, 2, 0, 0, 16'h8000);
    op1("R7", 0, 0, 0, 2, 0, 0, 16'h8000);
    // R5 logic operations clear carry and overflow
    wr("R5", 0, 2, 16'h0F0F);
    op1("R5", 0, 0, 0, 2, 0, 0, 16'hFFFF);
    op1("R5", 0, 0, 8, 2, 0, 0, 16'h3C3C);
    op1("R5", 0, 0, 9, 2, 0, 0, 16'h3C3C);
    op1("R5", 0, 0, 10, 2, 0, 0, 16'h0F0F);
    op1("R5", 0, 0, 11, 2, 0, 0, 16'h0000);
    // R6 overflow flag in both directions
    wr("R6", 0, 2, 16'h0001);
    op1("R6", 0, 0, 0, 2, 0, 0, 16'h7FFF);
    op1("R6", 0, 0, 2, 2, 0, 0, 16'h8000);
    // R8 destination selection
    op1("R8", 0, 0, 5, 2, 0, 1, 16'h0041);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);
    // R9 saturation into result only
    op1("R9", 0, 1, 0, 2, 0, 0, 16'h7FFF);
    op1("R9", 0, 1, 2, 2, 0, 0, 16'h8000);
    op1("R9", 0, 1, 4, 2, 0, 0, 16'h8000);
    op1("R9", 0, 1, 6, 2, 0, 0, 16'h8000);
    op1("R9", 0, 1, 0, 2, 0, 1, 16'h7FFF);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);
    op1("R9", 0, 0, 5, 2, 0, 0, 16'h7FFF);
    // R10 banking
    wr("R10", 1, 0, 16'h0101); wr("R10", 1, 2, 16'h0202);
    op1("R10", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, i);
    op1("R10", 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, i);
    // R11 invalid opcodes, idle, collision
    for (int o = 12; o < 16; o++) op1("R11", 0, 1, o, 2, 0, 0, 16'h7FFF);
    step("R11", 0, 0, 0, 0, 0, 0, 5, 2, 0, 0, 16'h1111, 5);
    step("R11", 0, 0, 1, 5, 16'h5555, 1, 5, 2, 0, 0, 16'h0100, 5);
    step("R11", 0, 0, 1, 4, 16'h6666, 1, 5, 2, 0, 1, 16'h0200, 4);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4);
    // mixed random traffic
    for (int n = 0; n < 600; n++)
      step("R11", $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 8, $urandom % 65536,
           $urandom % 4 != 0, $urandom % 16, $urandom % 4, $urandom % 4, $urandom % 2,
           $urandom % 65536, $urandom % 8);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule